// File: doc/BRIEF.md
# Virtual Function Interrupt Cause and Mask Unit

This block collects interrupt events for a network virtual function and turns them into message requests on three vectors. Each cycle it can take one event pulse from each of eight receive queues, eight transmit queues and a mailbox. It steers each event to a vector through programmable routing slots. A slot whose valid flag is clear drops its event.

Routed events latch into a cause register. Software can also set causes itself and clear them by writing ones. A vector whose cause and enable are both set becomes pending, and it holds a request with a valid/ready handshake on its own lane until the request is accepted. When the request is accepted, pending clears. If auto-masking is on for that vector, the vector's enable clears at the same time.

Software reaches every register through a 32-bit port with a 12-bit byte address. A write commits on the clock edge. A read returns data combinationally from the address.

Top module: `vf_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero and no message request is raised.
- R2: Routing register N (offset 0x120 + 4N, N = 0..3) holds four byte slots, from least significant: Rx queue 2N, Tx queue 2N, Rx queue 2N+1, Tx queue 2N+1. In each slot, bit 0 picks vector 0 or 1 and bit 7 is the valid flag. A read returns only these two bits per slot.
- R3: An event pulse on a queue whose slot is valid sets the cause bit of the selected vector after the next clock edge. An event on a queue whose slot is invalid sets nothing.
- R4: The mailbox routing register at 0x140 holds a 2-bit vector select in bits 1:0 and a valid flag in bit 7. A select of 3 drops the mailbox event.
- R5: Writing a 1 to a bit of the cause register (0x100, bits 2:0) clears that cause bit.
- R6: Writing a 1 to a bit of 0x104 sets that cause bit. A read of 0x104 returns zero.
- R7: Writing a 1 to 0x108 enables that vector, and a read of 0x108 returns the enable mask. Writing a 1 to 0x10C disables that vector, and a read of 0x10C returns zero.
- R8: A vector whose cause and enable are both 1 becomes pending one edge later. msg_valid shows the pending bits, which a read of 0x148 also returns.
- R9: An accepted request (msg_valid and msg_ready both high) clears pending at that edge. The request returns one edge later if cause and enable are still set.
- R10: When a vector's bit in the auto-mask register (0x114) is set, an accepted request also clears that vector's enable.
- R11: Writing a 1 to a bit of 0x148 clears that pending bit.
- R12: A hardware event and a clearing write to the same cause bit in the same cycle leave the bit set.
- R13: Bits above bit 2 read zero in the cause, enable, auto-mask and pending registers. An unmapped address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte address, used for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, available in the same cycle |
| rx_evt | input | 8 | Receive queue event pulses |
| tx_evt | input | 8 | Transmit queue event pulses |
| mbx_evt | input | 1 | Mailbox event pulse |
| msg_valid | output | 3 | Per-vector message request |
| msg_ready | input | 3 | Per-vector request acceptance |

## Verification
If an internal bit is wrong, it shows at the ports within one or two edges. A wrong routing slot puts an event on the wrong cause bit, or on none. The cause register can be read in the cycle right after the event. A wrong enable or a stuck pending bit shows on msg_valid one edge after the cause. A missed auto-mask shows as a request that comes back on the edge after acceptance. The tests therefore sample each of these at the exact edge where it should change, and at the edge after, to catch values that return.

// File: rtl/vf_irq_ctrl.sv
module vf_irq_ctrl #(
  parameter int NQ     = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NQ-1:0]     rx_evt,
  input  logic [NQ-1:0]     tx_evt,
  input  logic              mbx_evt,
  output logic [2:0]        msg_valid,
  input  logic [2:0]        msg_ready
);
  localparam int NV     = 3;
  localparam int NALLOC = NQ / 2;
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(12'h100);
  localparam logic [ADDR_W-1:0] A_CSET  = ADDR_W'(12'h104);
  localparam logic [ADDR_W-1:0] A_MSET  = ADDR_W'(12'h108);
  localparam logic [ADDR_W-1:0] A_MCLR  = ADDR_W'(12'h10C);
  localparam logic [ADDR_W-1:0] A_AUTO  = ADDR_W'(12'h114);
  localparam logic [ADDR_W-1:0] A_ROUTE = ADDR_W'(12'h120);
  localparam logic [ADDR_W-1:0] A_MBX   = ADDR_W'(12'h140);
  localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(12'h148);

  logic [NV-1:0] cause, en, automask, pend;
  logic [NQ-1:0] rx_sel, rx_vld, tx_sel, tx_vld;
  logic [1:0]    mbx_sel;
  logic          mbx_vld;
  logic [NV-1:0] hw_set, w1c, sw_set, mset, mclr, pclr, acc, ce;

  assign w1c    = (bus_wr && bus_addr == A_CAUSE) ? bus_wdata[NV-1:0] : '0;
  assign sw_set = (bus_wr && bus_addr == A_CSET)  ? bus_wdata[NV-1:0] : '0;
  assign mset   = (bus_wr && bus_addr == A_MSET)  ? bus_wdata[NV-1:0] : '0;
  assign mclr   = (bus_wr && bus_addr == A_MCLR)  ? bus_wdata[NV-1:0] : '0;
  assign pclr   = (bus_wr && bus_addr == A_PEND)  ? bus_wdata[NV-1:0] : '0;
  assign acc    = pend & msg_ready;
  assign ce     = cause & en;
  assign msg_valid = pend;

  always_comb begin
    hw_set = '0;
    for (int q = 0; q < NQ; q++) begin
      if (rx_evt[q] && rx_vld[q]) hw_set[rx_sel[q]] = 1'b1;
      if (tx_evt[q] && tx_vld[q]) hw_set[tx_sel[q]] = 1'b1;
    end
    if (mbx_evt && mbx_vld && mbx_sel != 2'd3) hw_set[mbx_sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause    <= '0;
      en       <= '0;
      automask <= '0;
      pend     <= '0;
      mbx_sel  <= '0;
      mbx_vld  <= 1'b0;
    end else begin
      cause <= (cause & ~w1c) | sw_set | hw_set;
      en    <= (en & ~mclr & ~(acc & automask)) | mset;
      pend  <= (pend | ce) & ~acc & ~pclr;
      if (bus_wr && bus_addr == A_AUTO) automask <= bus_wdata[NV-1:0];
      if (bus_wr && bus_addr == A_MBX) begin
        mbx_sel <= bus_wdata[1:0];
        mbx_vld <= bus_wdata[7];
      end
    end
  end

  for (genvar n = 0; n < NALLOC; n++) begin : g_route
    localparam logic [ADDR_W-1:0] A_N = A_ROUTE + ADDR_W'(4 * n);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rx_sel[2*n+:2] <= '0;
        rx_vld[2*n+:2] <= '0;
        tx_sel[2*n+:2] <= '0;
        tx_vld[2*n+:2] <= '0;
      end else if (bus_wr && bus_addr == A_N) begin
        rx_sel[2*n]   <= bus_wdata[0];
        rx_vld[2*n]   <= bus_wdata[7];
        tx_sel[2*n]   <= bus_wdata[8];
        tx_vld[2*n]   <= bus_wdata[15];
        rx_sel[2*n+1] <= bus_wdata[16];
        rx_vld[2*n+1] <= bus_wdata[23];
        tx_sel[2*n+1] <= bus_wdata[24];
        tx_vld[2*n+1] <= bus_wdata[31];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CAUSE: bus_rdata[NV-1:0] = cause;
      A_MSET:  bus_rdata[NV-1:0] = en;
      A_AUTO:  bus_rdata[NV-1:0] = automask;
      A_PEND:  bus_rdata[NV-1:0] = pend;
      A_MBX:   bus_rdata = {24'd0, mbx_vld, 5'd0, mbx_sel};
      default: begin
        for (int n = 0; n < NALLOC; n++) begin
          if (bus_addr == A_ROUTE + ADDR_W'(4 * n))
            bus_rdata = {tx_vld[2*n+1], 6'd0, tx_sel[2*n+1],
                         rx_vld[2*n+1], 6'd0, rx_sel[2*n+1],
                         tx_vld[2*n],   6'd0, tx_sel[2*n],
                         rx_vld[2*n],   6'd0, rx_sel[2*n]};
        end
      end
    endcase
  end
endmodule

module vf_irq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] bus_addr,
  input logic [31:0] bus_rdata,
  input logic [2:0]  cause,
  input logic [2:0]  en,
  input logic [2:0]  pend,
  input logic [2:0]  automask,
  input logic [2:0]  hw_set,
  input logic [2:0]  mset,
  input logic [2:0]  msg_valid,
  input logic [2:0]  msg_ready
);
  p_hw_beats_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != 3'd0) |=> ((cause & $past(hw_set)) == $past(hw_set)));

  p_pend_needs_cause_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(cause & en)) == 3'd0));

  p_accept_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((msg_valid & msg_ready) != 3'd0) |=> ((pend & $past(msg_valid & msg_ready)) == 3'd0));

  p_automask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((msg_valid & msg_ready & automask) != 3'd0)
      |=> ((en & $past(msg_valid & msg_ready & automask & ~mset)) == 3'd0));

  p_upper_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr < 12'h120 || bus_addr > 12'h12C) |-> (bus_rdata[31:8] == 24'd0));
endmodule

bind vf_irq_ctrl vf_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .cause(cause), .en(en), .pend(pend), .automask(automask),
  .hw_set(hw_set), .mset(mset), .msg_valid(msg_valid), .msg_ready(msg_ready)
);

// File: tb/vf_irq_ctrl_tb.sv
module vf_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  rx_evt = '0, tx_evt = '0;
  logic        mbx_evt = 1'b0;
  logic [2:0]  msg_valid, msg_ready = '0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vf_irq_ctrl dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(logic [11:0] a, string req, logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic t_reset();
    rd(12'h100, "R1 cause", 0);
    rd(12'h108, "R1 enable", 0);
    rd(12'h114, "R1 automask", 0);
    rd(12'h120, "R1 route0", 0);
    rd(12'h140, "R1 mbx", 0);
    rd(12'h148, "R1 pending", 0);
    chk("R1 msg_valid", msg_valid, 0);
  endtask

  task automatic t_route();
    wr(12'h120, 32'h81800181);
    rd(12'h120, "R2 readback", 32'h81800181);
    wr(12'h12C, 32'hFF7E_0000);
    rd(12'h12C, "R2 masked readback", 32'h8100_0000);
    tx_evt[0] = 1'b1; tick(); tx_evt[0] = 1'b0;
    rd(12'h100, "R3 invalid slot dropped", 0);
    rx_evt[0] = 1'b1; tick(); rx_evt[0] = 1'b0;
    rd(12'h100, "R3 rx0 to vector1", 3'b010);
    wr(12'h100, 7);
    rx_evt[1] = 1'b1; tick(); rx_evt[1] = 1'b0;
    rd(12'h100, "R3 rx1 to vector0", 3'b001);
    wr(12'h100, 7);
    tx_evt[7] = 1'b1; tick(); tx_evt[7] = 1'b0;
    rd(12'h100, "R3 tx7 to vector1", 3'b010);
    wr(12'h100, 7);
  endtask

  task automatic t_mbx();
    wr(12'h140, 32'h82);
    rd(12'h140, "R4 readback", 32'h82);
    mbx_evt = 1'b1; tick(); mbx_evt = 1'b0;
    rd(12'h100, "R4 mailbox to vector2", 3'b100);
    wr(12'h100, 7);
    wr(12'h140, 32'h83);
    mbx_evt = 1'b1; tick(); mbx_evt = 1'b0;
    rd(12'h100, "R4 select 3 ignored", 0);
  endtask

  task automatic t_sw();
    wr(12'h104, 5);
    rd(12'h100, "R6 cause set", 5);
    rd(12'h104, "R6 set reg reads zero", 0);
    wr(12'h100, 1);
    rd(12'h100, "R5 w1c one bit", 4);
    wr(12'h100, 4);
    rd(12'h100, "R5 w1c all", 0);
  endtask

  task automatic t_prio();
    wr(12'h140, 32'h82);
    wr(12'h104, 4);
    mbx_evt = 1'b1;
    wr(12'h100, 4);
    mbx_evt = 1'b0;
    rd(12'h100, "R12 hw set beats clear", 4);
    wr(12'h100, 7);
  endtask

  task automatic t_mask_pend();
    wr(12'h108, 3);
    rd(12'h108, "R7 mask set", 3);
    wr(12'h10C, 1);
    rd(12'h108, "R7 mask clear", 2);
    rd(12'h10C, "R7 clear reg reads zero", 0);
    wr(12'h104, 2);
    chk("R8 not yet pending", msg_valid, 0);
    tick();
    chk("R8 pending request", msg_valid, 3'b010);
    rd(12'h148, "R8 pending readback", 3'b010);
    msg_ready = 3'b010; tick(); msg_ready = 3'b000;
    chk("R9 accept clears", msg_valid, 0);
    tick();
    chk("R9 request returns", msg_valid, 3'b010);
  endtask

  task automatic t_auto();
    wr(12'h114, 2);
    rd(12'h114, "R10 automask readback", 2);
    tick();
    msg_ready = 3'b010; tick(); msg_ready = 3'b000;
    rd(12'h108, "R10 enable cleared", 0);
    tick(); tick();
    chk("R10 no new request", msg_valid, 0);
    rd(12'h100, "R10 cause kept", 2);
    wr(12'h100, 7);
  endtask

  task automatic t_pclr();
    wr(12'h108, 4);
    wr(12'h104, 4);
    tick();
    chk("R11 pending before clear", msg_valid, 3'b100);
    wr(12'h148, 4);
    rd(12'h148, "R11 pending cleared", 0);
    tick();
    chk("R11 pending returns from cause", msg_valid, 3'b100);
    wr(12'h10C, 7);
    wr(12'h148, 7);
    wr(12'h100, 7);
  endtask

  task automatic t_upper();
    wr(12'h108, 32'hFFFF_FFFF);
    rd(12'h108, "R13 upper bits zero", 7);
    wr(12'h10C, 7);
    rd(12'h200, "R13 unmapped zero", 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_route();
    t_mbx();
    t_sw();
    t_prio();
    t_mask_pend();
    t_auto();
    t_pclr();
    t_upper();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule